// File: doc/BRIEF.md
# Masked Input Change Interrupt

This block watches forty synchronised pin levels, grouped as five banks of eight, and raises one active-low interrupt when a pin that is allowed to interrupt changes level. A pin may interrupt only when it is set up as an input and its bit in an internal per-bank mask register is clear. The block keeps a snapshot of each pin's level. A pin is pending while its live level differs from its snapshot.

The surrounding register interface sends the block two kinds of event. The first is a write of one 8-bit mask bank. The second is a strobe that marks a read of one input bank. A read reloads that bank's snapshot with the current levels and drops that bank's pending changes. A pending change also goes away without a read if the pin returns to its snapshot level.

The interrupt output is a registered signal: low means the open-drain pad should pull the line low. The pad electricals are not part of this block.

Top module: `change_irq`

## Requirements
- R1: While reset is asserted, and after any reset, `intN` is 1 and every mask bit is 1, so pin changes do not lower `intN` until a mask bank is written.
- R2: A change on an unmasked input pin lowers `intN` at the first rising clock edge at which the new level is present.
- R3: Mask bank b bit j controls pin 8*b+j. A 1 blocks that pin from interrupting, and a 0 allows it.
- R4: A pin with `pinIsInput` at 0 never lowers `intN`, whatever its level does.
- R5: If a pending pin returns to its snapshot level and no other pin is pending, `intN` returns to 1 at the next edge.
- R6: A read strobe for bank b reloads that bank's snapshot and clears its pending changes at the same edge, including a change that arrives in that same cycle. Other banks are not affected.
- R7: Switching a pin from output to input loads its snapshot with its level in that cycle, so the switch alone does not lower `intN`.
- R8: Clearing a mask bit for a pin whose level differs from its snapshot lowers `intN` one edge after the edge that writes the mask.
- R9: A mask write or read strobe with a bank index of 5, 6 or 7 has no effect.
- R10: `intN` is registered. It changes only at rising clock edges and equals the inverted OR of the previous cycle's pending pins.
- R11: At the first edge after reset, the snapshot of every input pin is loaded from the pin levels, so a non-zero pin pattern present at reset does not interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | 40 | Synchronised pin levels, bank b in bits 8*b+7..8*b |
| pinIsInput | input | 40 | Direction per pin, 1 = input |
| rdStrobe | input | 1 | One-cycle marker of an input bank read |
| rdBank | input | 3 | Bank being read |
| maskWrEn | input | 1 | Mask bank write enable |
| maskWrBank | input | 3 | Mask bank to write |
| maskWrData | input | 8 | New mask bank contents, 1 = blocked |
| intN | output | 1 | Interrupt, 0 = pull line low |

## Verification
The assertions assume that `pinLevel` and `pinIsInput` are already synchronous to `clk`. They also assume that every strobe lasts exactly one cycle and is low during reset. The bench meets these assumptions by changing every input just after a rising edge and by dropping each strobe after one edge. Reads and mask writes with out-of-range bank indices are driven on purpose, because the block must accept and ignore them.

// File: rtl/chgirq_pkg.sv
`timescale 1ns/1ps
package chgirq_pkg;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_W     = 8;
  localparam int PIN_W      = NUM_BANKS * BANK_W;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  // Strobes sent by control to the datapath each cycle.
  typedef struct packed {
    logic [NUM_BANKS-1:0] readHit;   // bank being read this cycle
    logic [NUM_BANKS-1:0] maskLoad;  // bank mask being written
    logic [BANK_W-1:0]    maskData;  // new mask bank value
  } chgirq_strobe_t;
endpackage

// File: rtl/chgirq_ctrl.sv
`timescale 1ns/1ps
module chgirq_ctrl
  import chgirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdStrobe,
  input  logic [BANK_IDX_W-1:0] rdBank,
  input  logic                  maskWrEn,
  input  logic [BANK_IDX_W-1:0] maskWrBank,
  input  logic [BANK_W-1:0]     maskWrData,
  input  logic                  anyPending,
  output chgirq_strobe_t        stb,
  output logic                  intN
);
  // Bank decode; indices past the last bank match nothing.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign stb.readHit[b]  = rdStrobe && (rdBank == BANK_IDX_W'(b));
    assign stb.maskLoad[b] = maskWrEn && (maskWrBank == BANK_IDX_W'(b));
  end
  assign stb.maskData = maskWrData;

  // Registered output keeps combinational glitches off the pad.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intN <= 1'b1;
    else       intN <= ~anyPending;
  end
endmodule

// File: rtl/chgirq_dpath.sv
`timescale 1ns/1ps
module chgirq_dpath
  import chgirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chgirq_strobe_t   stb,
  input  logic [PIN_W-1:0] pinLevel,
  input  logic [PIN_W-1:0] pinIsInput,
  output logic             anyPending
);
  logic [PIN_W-1:0] maskQ;
  logic [PIN_W-1:0] snapQ;
  logic [PIN_W-1:0] dirPrevQ;
  logic [PIN_W-1:0] readClr;
  logic [PIN_W-1:0] entry;
  logic [PIN_W-1:0] snapLoad;
  logic [PIN_W-1:0] pendVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign readClr[b*BANK_W +: BANK_W] = {BANK_W{stb.readHit[b]}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                maskQ[b*BANK_W +: BANK_W] <= '1;
      else if (stb.maskLoad[b]) maskQ[b*BANK_W +: BANK_W] <= stb.maskData;
    end
  end

  // dirPrevQ resets to zero, so every input pin counts as newly entered at
  // the first edge after reset and its snapshot is captured there.
  assign entry    = pinIsInput & ~dirPrevQ;
  assign snapLoad = entry | readClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirPrevQ <= '0;
      snapQ    <= '0;
    end else begin
      dirPrevQ <= pinIsInput;
      snapQ    <= (snapQ & ~snapLoad) | (pinLevel & snapLoad);
    end
  end

  assign pendVec    = pinIsInput & dirPrevQ & ~maskQ & ~readClr & (pinLevel ^ snapQ);
  assign anyPending = |pendVec;
endmodule

// File: rtl/change_irq.sv
`timescale 1ns/1ps
module change_irq
  import chgirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_W-1:0]      pinLevel,
  input  logic [PIN_W-1:0]      pinIsInput,
  input  logic                  rdStrobe,
  input  logic [BANK_IDX_W-1:0] rdBank,
  input  logic                  maskWrEn,
  input  logic [BANK_IDX_W-1:0] maskWrBank,
  input  logic [BANK_W-1:0]     maskWrData,
  output logic                  intN
);
  chgirq_strobe_t stb;
  logic           anyPending;

  chgirq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdBank(rdBank),
    .maskWrEn(maskWrEn), .maskWrBank(maskWrBank), .maskWrData(maskWrData),
    .anyPending(anyPending), .stb(stb), .intN(intN)
  );

  chgirq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pinLevel(pinLevel),
    .pinIsInput(pinIsInput), .anyPending(anyPending)
  );
endmodule

// File: rtl/change_irq_chk.sv
`timescale 1ns/1ps
module change_irq_chk
  import chgirq_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [PIN_W-1:0]      pinLevel,
  input logic [PIN_W-1:0]      pinIsInput,
  input logic                  rdStrobe,
  input logic [BANK_IDX_W-1:0] rdBank,
  input logic                  maskWrEn,
  input logic [BANK_IDX_W-1:0] maskWrBank,
  input logic [BANK_W-1:0]     maskWrData,
  input logic                  intN
);
  // Set once any in-range mask bank has been written since reset.
  logic maskSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskSeen <= 1'b0;
    else if (maskWrEn && (maskWrBank < BANK_IDX_W'(NUM_BANKS))) maskSeen <= 1'b1;
  end

  // R1: output idle during reset
  always @(negedge clk) begin
    if (!rstN) p_rst_idle_r1: assert (intN === 1'b1);
  end

  // R1, R9: default masks hold intN high until a valid bank is written
  p_mask_default_r9: assert property (@(posedge clk) disable iff (!rstN)
    !maskSeen |-> intN);

  // R4: with every pin an output nothing can be pending
  p_output_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pinIsInput == '0) |=> intN);

  // R7: a pin entering input mode cannot be pending in its entry cycle
  p_dir_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pinIsInput == '0) |=> ##1 intN);

  // R10: a falling intN needs an input pin in the cycle before
  p_fall_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> ($past(pinIsInput) != '0));
endmodule

bind change_irq change_irq_chk i_chk (
  .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinIsInput(pinIsInput),
  .rdStrobe(rdStrobe), .rdBank(rdBank), .maskWrEn(maskWrEn),
  .maskWrBank(maskWrBank), .maskWrData(maskWrData), .intN(intN)
);

// File: tb/test_change_irq.sv
`timescale 1ns/1ps
module test_change_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] pinLevel = 40'hA5_5A_F0_0F_33;
  logic [39:0] pinIsInput = '1;
  logic        rdStrobe = 1'b0;
  logic [2:0]  rdBank = '0;
  logic        maskWrEn = 1'b0;
  logic [2:0]  maskWrBank = '0;
  logic [7:0]  maskWrData = '0;
  logic        intN;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  change_irq i_change_irq (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinIsInput(pinIsInput),
    .rdStrobe(rdStrobe), .rdBank(rdBank), .maskWrEn(maskWrEn),
    .maskWrBank(maskWrBank), .maskWrData(maskWrData), .intN(intN)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic exp);
    nChecks++;
    if (intN !== exp) begin
      nErr++;
      $display("FAIL %s: intN=%b expected %b", req, intN, exp);
    end
  endtask

  task automatic writeMask(int bank, logic [7:0] data);
    maskWrEn = 1'b1; maskWrBank = 3'(bank); maskWrData = data;
    step(1);
    maskWrEn = 1'b0;
  endtask

  task automatic readBank(int bank);
    rdStrobe = 1'b1; rdBank = 3'(bank);
    step(1);
    rdStrobe = 1'b0;
  endtask

  task automatic flip(int pin);
    pinLevel[pin] = ~pinLevel[pin];
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 during reset", 1'b1);
    rstN = 1'b1;
    step(3);
    chk("R1 after reset", 1'b1);
    flip(7); flip(30);
    step(2);
    chk("R1 default masks", 1'b1);
    flip(7); flip(30);
    step(1);
  endtask

  task automatic t_unmask_all;
    for (int b = 0; b < 5; b++) writeMask(b, 8'h00);
    step(2);
    chk("R11 snapshot taken at reset", 1'b1);
  endtask

  task automatic t_change_return;
    flip(13);
    step(1);
    chk("R2 change raises", 1'b0);
    flip(13);
    step(1);
    chk("R5 return clears", 1'b1);
  endtask

  task automatic t_read_clear;
    flip(20);
    step(1);
    chk("R2 bank2 change", 1'b0);
    readBank(2);
    chk("R6 read clears same edge", 1'b1);
    step(2);
    chk("R6 new level is snapshot", 1'b1);
    flip(35);
    step(1);
    chk("R2 bank4 change", 1'b0);
    readBank(0);
    chk("R6 other bank read keeps pending", 1'b0);
    readBank(4);
    chk("R6 own bank read clears", 1'b1);
  endtask

  task automatic t_mask;
    writeMask(3, 8'hFF);
    flip(26);
    step(2);
    chk("R3 masked pin quiet", 1'b1);
    writeMask(3, 8'hFB);
    chk("R8 not yet at write edge", 1'b1);
    step(1);
    chk("R8 unmask with difference", 1'b0);
    readBank(3);
    chk("R6 bank3 read", 1'b1);
    flip(24);
    step(2);
    chk("R3 bit0 still masked", 1'b1);
    flip(26);
    step(1);
    chk("R3 bit2 enables pin 26", 1'b0);
    flip(26);
    step(1);
    chk("R5 pin 26 back", 1'b1);
  endtask

  task automatic t_direction;
    pinIsInput[5] = 1'b0;
    step(2);
    flip(5);
    step(2);
    chk("R4 output pin quiet", 1'b1);
    pinIsInput[5] = 1'b1;
    step(1);
    chk("R7 entry cycle", 1'b1);
    step(2);
    chk("R7 entry no interrupt", 1'b1);
    flip(5);
    step(1);
    chk("R7 snapshot is switch level", 1'b0);
    flip(5);
    step(1);
    chk("R7 back to switch level", 1'b1);
  endtask

  task automatic t_bad_bank;
    writeMask(5, 8'hFF);
    writeMask(6, 8'hFF);
    writeMask(7, 8'hFF);
    flip(9);
    step(1);
    chk("R9 bad mask write ignored", 1'b0);
    flip(9);
    step(1);
    chk("R5 pin 9 back", 1'b1);
    flip(17);
    step(1);
    chk("R2 pin 17 change", 1'b0);
    readBank(5);
    chk("R9 bad read ignored", 1'b0);
    readBank(7);
    step(1);
    chk("R9 still pending", 1'b0);
    readBank(2);
    chk("R6 bank2 read clears", 1'b1);
  endtask

  task automatic t_latency;
    flip(3);
    #1;
    chk("R10 no change between edges", 1'b1);
    step(1);
    chk("R10 change at edge", 1'b0);
    flip(3);
    step(1);
    chk("R5 pin 3 back", 1'b1);
    flip(12);
    rdStrobe = 1'b1; rdBank = 3'd1;
    step(1);
    rdStrobe = 1'b0;
    chk("R6 change and read same cycle", 1'b1);
    step(2);
    chk("R6 same-cycle change absorbed", 1'b1);
  endtask

  task automatic t_mid_reset;
    flip(1);
    step(1);
    chk("R2 pin 1 change", 1'b0);
    rstN = 1'b0;
    step(1);
    chk("R1 reset drops pending", 1'b1);
    rstN = 1'b1;
    step(2);
    chk("R1 idle after reset", 1'b1);
    flip(1);
    step(2);
    chk("R1 masks back to ones", 1'b1);
  endtask

  initial begin
    t_reset;
    t_unmask_all;
    t_change_return;
    t_read_clear;
    t_mask;
    t_direction;
    t_bad_bank;
    t_latency;
    t_mid_reset;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule